// File: doc/BRIEF.md
# Doorbell-Driven Virtual Register Mailbox

This block is the controller side of a ten-byte, byte-wide register window through which a host reaches a small array of byte-wide virtual registers that carry 16-bit addresses. The host never addresses a virtual register directly. It first steers a 16-bit window pointer into an eight-byte packet buffer. Through four window bytes it then writes a request: an opcode, an entry count, a value byte and a virtual address. Finally it writes the go code to the doorbell byte.

After a programmable wait, a command engine checks the request. It performs a single read or write on the virtual register array and posts a result code. It also raises a completion bit in a write-one-to-clear interrupt source byte. A read places its result back in the buffer, where the host fetches it through the window. A second interrupt source byte records rising edges of an external watchdog event, and an interrupt output reflects both sources.

The controller updates live values through a separate port. Some quantities span two adjacent virtual registers. For these, an engine read of the even member captures the odd member at that moment, so the pair the host sees is coherent.

Top module: `mbx_mailbox_top`

## Requirements
- R1: After reset every window offset 0..9 reads 0x00 and `irq` is low.
- R2: Writes to offset 2 and offset 3 set the low and high byte of the window pointer, and reading those offsets returns them.
- R3: Offsets 4..7 reach packet byte (pointer[2:0] + offset - 4) only when pointer[15:3] equals 0x8000>>3 and that index is below 8. Outside that range a write is ignored and a read returns 0x00. The byte layout is: 0 opcode, 1 entry count, 4 value, 6 virtual address low, 7 virtual address high.
- R4: Writing 0x01 to offset 0 while idle starts a command, and `irq` rises exactly RESP_DELAY+2 cycles after that write. A doorbell write of any other value starts nothing.
- R5: Opcode 0x03 with count 1 and a virtual address below 2**VADDR_W stores packet byte 4 into that virtual register.
- R6: Opcode 0x02 with count 1 and a virtual address in range copies the virtual register into packet byte 4.
- R7: The result code at offset 1 is 0x01 on success, 0x80 for an unknown opcode or a count other than 1, and 0x81 for an out-of-range address. A failed command changes no virtual register.
- R8: A write to offset 1 clears the result code bits written as 1.
- R9: Bit 0 of offset 8 sets when a command completes and is cleared by writing 1 to it.
- R10: Bit 0 of offset 9 sets on each rising edge of `wdog_evt`, is cleared by writing 1 to it, and does not set again while the event stays high.
- R11: A doorbell written while a command is in progress is ignored and produces no second completion.
- R12: An engine read of an even virtual address latches the odd partner. The next engine read of that odd address returns the latched byte even if the partner was updated in between, and consumes the latch. Any other read returns the live value.
- R13: `irq` is high exactly when bit 0 of offset 8 or bit 0 of offset 9 is set.
- R14: A write on the controller update port stores `ctl_upd_data` into the virtual register at `ctl_upd_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_sel | input | 1 | Host access strobe, one cycle per access |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 4 | Window offset |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Read data, registered, valid the cycle after the read strobe |
| wdog_evt | input | 1 | External watchdog event level |
| ctl_upd_we | input | 1 | Controller update write enable |
| ctl_upd_addr | input | VADDR_W | Controller update virtual address |
| ctl_upd_data | input | 8 | Controller update data |
| irq | output | 1 | Interrupt, OR of both source bits |

## Verification
The hardest case to reach is the partner latch when the odd register changes between the two halves of a pair read. That takes an even read command, then a controller update of the odd partner, then a read command of the odd address. The bench drives this in a directed sequence. Its random phase also mixes update-port writes with read commands, and a reference model of the array and the latch follows along. A second hard case is a doorbell that arrives during the response wait. The bench issues two doorbells in consecutive accesses and then watches for a second completion that must never come.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam logic [7:0] OP_READ     = 8'h02;
  localparam logic [7:0] OP_WRITE    = 8'h03;
  localparam logic [7:0] ST_OK       = 8'h01;
  localparam logic [7:0] ST_BAD_CMD  = 8'h80;
  localparam logic [7:0] ST_BAD_ADDR = 8'h81;
  localparam logic [7:0] DOORBELL_GO = 8'h01;

  localparam logic [15:0] PKT_BASE = 16'h8000;
  localparam int PKT_BYTES = 8;
  localparam int IDX_OP    = 0;
  localparam int IDX_COUNT = 1;
  localparam int IDX_VALUE = 4;
  localparam int IDX_ALO   = 6;
  localparam int IDX_AHI   = 7;

  localparam logic [3:0] OFF_DOORBELL = 4'd0;
  localparam logic [3:0] OFF_RESULT   = 4'd1;
  localparam logic [3:0] OFF_PTR_LO   = 4'd2;
  localparam logic [3:0] OFF_PTR_HI   = 4'd3;
  localparam logic [3:0] OFF_INT_CMD  = 4'd8;
  localparam logic [3:0] OFF_INT_WDOG = 4'd9;

  typedef enum logic [1:0] {ENG_IDLE, ENG_WAIT, ENG_ACCESS, ENG_DONE} eng_state_t;

  typedef struct packed {
    logic [7:0]  op;
    logic [7:0]  count;
    logic [15:0] vaddr;
    logic [7:0]  value;
  } mbx_pkt_t;
endpackage

// File: rtl/mbx_host_regs.sv
module mbx_host_regs
  import mbx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       host_sel,
  input  logic       host_we,
  input  logic [3:0] host_addr,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata,
  output logic       doorbell_o,
  output mbx_pkt_t   pkt_o,
  input  logic       res_we_i,
  input  logic [7:0] res_data_i,
  input  logic       done_i,
  input  logic [7:0] done_status_i,
  input  logic       wdog_evt_i,
  output logic       irq_o
);
  logic [15:0] ptr_q;
  logic [7:0]  result_q;
  logic        int_cmd_q;
  logic        int_wdog_q;
  logic        evt_q;
  logic [7:0]  rdata_q;
  logic [7:0]  pkt_buf [PKT_BYTES];

  logic       wr_go, rd_go, win_sel, win_hit;
  logic [3:0] win_idx;

  always_comb begin
    wr_go   = host_sel & host_we;
    rd_go   = host_sel & ~host_we;
    win_sel = (host_addr[3:2] == 2'b01);
    win_idx = {1'b0, ptr_q[2:0]} + {2'b00, host_addr[1:0]};
    win_hit = (ptr_q[15:3] == PKT_BASE[15:3]) && !win_idx[3];
  end

  assign doorbell_o = wr_go && (host_addr == OFF_DOORBELL) && (host_wdata == DOORBELL_GO);
  assign irq_o      = int_cmd_q | int_wdog_q;
  assign host_rdata = rdata_q;

  always_comb begin
    pkt_o.op    = pkt_buf[IDX_OP];
    pkt_o.count = pkt_buf[IDX_COUNT];
    pkt_o.vaddr = {pkt_buf[IDX_AHI], pkt_buf[IDX_ALO]};
    pkt_o.value = pkt_buf[IDX_VALUE];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q      <= '0;
      result_q   <= '0;
      int_cmd_q  <= 1'b0;
      int_wdog_q <= 1'b0;
      evt_q      <= 1'b0;
    end else begin
      evt_q <= wdog_evt_i;
      if (wr_go && host_addr == OFF_PTR_LO) ptr_q[7:0]  <= host_wdata;
      if (wr_go && host_addr == OFF_PTR_HI) ptr_q[15:8] <= host_wdata;
      if (done_i)
        result_q <= done_status_i;
      else if (wr_go && host_addr == OFF_RESULT)
        result_q <= result_q & ~host_wdata;
      if (done_i)
        int_cmd_q <= 1'b1;
      else if (wr_go && host_addr == OFF_INT_CMD && host_wdata[0])
        int_cmd_q <= 1'b0;
      if (wdog_evt_i && !evt_q)
        int_wdog_q <= 1'b1;
      else if (wr_go && host_addr == OFF_INT_WDOG && host_wdata[0])
        int_wdog_q <= 1'b0;
    end
  end

  for (genvar gi = 0; gi < PKT_BYTES; gi++) begin : g_buf
    always_ff @(posedge clk) begin
      if (rst)
        pkt_buf[gi] <= '0;
      else if (res_we_i && gi == IDX_VALUE)
        pkt_buf[gi] <= res_data_i;
      else if (wr_go && win_sel && win_hit && win_idx[2:0] == 3'(gi))
        pkt_buf[gi] <= host_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (rd_go) begin
      if (win_sel)
        rdata_q <= win_hit ? pkt_buf[win_idx[2:0]] : 8'h00;
      else begin
        case (host_addr)
          OFF_RESULT:   rdata_q <= result_q;
          OFF_PTR_LO:   rdata_q <= ptr_q[7:0];
          OFF_PTR_HI:   rdata_q <= ptr_q[15:8];
          OFF_INT_CMD:  rdata_q <= {7'b0, int_cmd_q};
          OFF_INT_WDOG: rdata_q <= {7'b0, int_wdog_q};
          default:      rdata_q <= 8'h00;
        endcase
      end
    end
  end

  p_cmd_int_source_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(int_cmd_q) |-> $past(done_i));
  p_result_posted_r7: assert property (@(posedge clk) disable iff (rst)
    done_i |=> result_q != 8'h00);
  p_wdog_edge_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(int_wdog_q) |-> $past(wdog_evt_i));
  p_ptr_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !(wr_go && (host_addr == OFF_PTR_LO || host_addr == OFF_PTR_HI)) |=> $stable(ptr_q));
endmodule

// File: rtl/mbx_cmd_engine.sv
module mbx_cmd_engine
  import mbx_pkg::*;
#(
  parameter int RESP_DELAY = 6,
  parameter int VADDR_W    = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               doorbell_i,
  input  mbx_pkt_t           pkt_i,
  output logic               vr_re_o,
  output logic               vr_we_o,
  output logic [VADDR_W-1:0] vr_addr_o,
  output logic [7:0]         vr_wdata_o,
  input  logic [7:0]         vr_rdata_i,
  output logic               res_we_o,
  output logic [7:0]         res_data_o,
  output logic               done_o,
  output logic [7:0]         done_status_o
);
  localparam int CNT_W = $clog2(RESP_DELAY + 1);
  localparam int LAT_W = $clog2(RESP_DELAY + 4);

  eng_state_t         state_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [7:0]         status_q;
  logic               is_read_q;
  logic               re_q, we_q;
  logic [VADDR_W-1:0] addr_q;
  logic [7:0]         wdata_q;
  logic [LAT_W-1:0]   lat_q;

  logic op_ok, addr_ok;
  always_comb begin
    op_ok   = ((pkt_i.op == OP_READ) || (pkt_i.op == OP_WRITE)) && (pkt_i.count == 8'd1);
    addr_ok = (pkt_i.vaddr[15:VADDR_W] == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ENG_IDLE;
      cnt_q     <= '0;
      status_q  <= '0;
      is_read_q <= 1'b0;
      re_q      <= 1'b0;
      we_q      <= 1'b0;
      addr_q    <= '0;
      wdata_q   <= '0;
    end else begin
      case (state_q)
        ENG_IDLE: if (doorbell_i) begin
          state_q <= ENG_WAIT;
          cnt_q   <= '0;
        end
        ENG_WAIT: if (cnt_q == CNT_W'(RESP_DELAY - 1)) begin
          state_q   <= ENG_ACCESS;
          addr_q    <= pkt_i.vaddr[VADDR_W-1:0];
          wdata_q   <= pkt_i.value;
          is_read_q <= (pkt_i.op == OP_READ);
          if (!op_ok) begin
            status_q <= ST_BAD_CMD;
          end else if (!addr_ok) begin
            status_q <= ST_BAD_ADDR;
          end else begin
            status_q <= ST_OK;
            re_q     <= (pkt_i.op == OP_READ);
            we_q     <= (pkt_i.op == OP_WRITE);
          end
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
        ENG_ACCESS: begin
          re_q    <= 1'b0;
          we_q    <= 1'b0;
          state_q <= ENG_DONE;
        end
        default: state_q <= ENG_IDLE;
      endcase
    end
  end

  assign vr_re_o       = re_q;
  assign vr_we_o       = we_q;
  assign vr_addr_o     = addr_q;
  assign vr_wdata_o    = wdata_q;
  assign done_o        = (state_q == ENG_DONE);
  assign done_status_o = status_q;
  assign res_we_o      = done_o && is_read_q && (status_q == ST_OK);
  assign res_data_o    = vr_rdata_i;

  always_ff @(posedge clk) begin
    if (rst)
      lat_q <= '0;
    else if (state_q == ENG_IDLE && doorbell_i)
      lat_q <= '0;
    else if (state_q != ENG_IDLE)
      lat_q <= lat_q + 1'b1;
  end

  p_latency_r4: assert property (@(posedge clk) disable iff (rst)
    done_o |-> lat_q == LAT_W'(RESP_DELAY + 1));
  p_busy_ignore_r11: assert property (@(posedge clk) disable iff (rst)
    (state_q != ENG_IDLE && doorbell_i) |=> lat_q == $past(lat_q) + 1'b1);
  p_err_no_write_r7: assert property (@(posedge clk) disable iff (rst)
    (done_o && done_status_o != ST_OK) |-> !$past(vr_we_o));
endmodule

// File: rtl/mbx_vreg_array.sv
module mbx_vreg_array #(
  parameter int VADDR_W = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               eng_re,
  input  logic               eng_we,
  input  logic [VADDR_W-1:0] eng_addr,
  input  logic [7:0]         eng_wdata,
  output logic [7:0]         eng_rdata,
  input  logic               upd_we,
  input  logic [VADDR_W-1:0] upd_addr,
  input  logic [7:0]         upd_data
);
  localparam int DEPTH = 1 << VADDR_W;

  logic [7:0]         mem [DEPTH];
  logic [7:0]         shadow_q;
  logic [VADDR_W-1:0] shadow_addr_q;
  logic               shadow_vld_q;
  logic [7:0]         rdata_q;
  logic [VADDR_W-1:0] partner_addr;

  assign partner_addr = eng_addr | VADDR_W'(1);
  assign eng_rdata    = rdata_q;

  always_ff @(posedge clk) begin
    if (upd_we && !(eng_we && eng_addr == upd_addr))
      mem[upd_addr] <= upd_data;
    if (eng_we)
      mem[eng_addr] <= eng_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_q      <= '0;
      shadow_addr_q <= '0;
      shadow_vld_q  <= 1'b0;
      rdata_q       <= '0;
    end else if (eng_re) begin
      if (!eng_addr[0]) begin
        rdata_q       <= mem[eng_addr];
        shadow_q      <= mem[partner_addr];
        shadow_addr_q <= partner_addr;
        shadow_vld_q  <= 1'b1;
      end else if (shadow_vld_q && shadow_addr_q == eng_addr) begin
        rdata_q      <= shadow_q;
        shadow_vld_q <= 1'b0;
      end else begin
        rdata_q <= mem[eng_addr];
      end
    end
  end

  p_one_access_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0({eng_re, eng_we}));
  p_latch_armed_r12: assert property (@(posedge clk) disable iff (rst)
    (eng_re && !eng_addr[0]) |=> shadow_vld_q && shadow_addr_q[0]);
endmodule

// File: rtl/mbx_mailbox_top.sv
module mbx_mailbox_top
  import mbx_pkg::*;
#(
  parameter int RESP_DELAY = 6,
  parameter int VADDR_W    = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               host_sel,
  input  logic               host_we,
  input  logic [3:0]         host_addr,
  input  logic [7:0]         host_wdata,
  output logic [7:0]         host_rdata,
  input  logic               wdog_evt,
  input  logic               ctl_upd_we,
  input  logic [VADDR_W-1:0] ctl_upd_addr,
  input  logic [7:0]         ctl_upd_data,
  output logic               irq
);
  mbx_pkt_t           pkt;
  logic               doorbell, res_we, done;
  logic [7:0]         res_data, done_status;
  logic               vr_re, vr_we;
  logic [VADDR_W-1:0] vr_addr;
  logic [7:0]         vr_wdata, vr_rdata;

  mbx_host_regs u_regs (
    .clk(clk), .rst(rst),
    .host_sel(host_sel), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .doorbell_o(doorbell), .pkt_o(pkt),
    .res_we_i(res_we), .res_data_i(res_data),
    .done_i(done), .done_status_i(done_status),
    .wdog_evt_i(wdog_evt), .irq_o(irq)
  );

  mbx_cmd_engine #(.RESP_DELAY(RESP_DELAY), .VADDR_W(VADDR_W)) u_eng (
    .clk(clk), .rst(rst),
    .doorbell_i(doorbell), .pkt_i(pkt),
    .vr_re_o(vr_re), .vr_we_o(vr_we), .vr_addr_o(vr_addr),
    .vr_wdata_o(vr_wdata), .vr_rdata_i(vr_rdata),
    .res_we_o(res_we), .res_data_o(res_data),
    .done_o(done), .done_status_o(done_status)
  );

  mbx_vreg_array #(.VADDR_W(VADDR_W)) u_vregs (
    .clk(clk), .rst(rst),
    .eng_re(vr_re), .eng_we(vr_we), .eng_addr(vr_addr),
    .eng_wdata(vr_wdata), .eng_rdata(vr_rdata),
    .upd_we(ctl_upd_we), .upd_addr(ctl_upd_addr), .upd_data(ctl_upd_data)
  );

  p_irq_sources_r13: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(done) || $past(wdog_evt));
endmodule

// File: tb/mbx_mailbox_top_tb_top.sv
module mbx_mailbox_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DLY = 5;
  localparam int VW  = 6;
  localparam int VDEPTH = 1 << VW;

  logic clk = 1'b0, rst = 1'b1;
  logic host_sel = 0, host_we = 0;
  logic [3:0] host_addr = '0;
  logic [7:0] host_wdata = '0, host_rdata;
  logic wdog_evt = 0, ctl_upd_we = 0, irq;
  logic [VW-1:0] ctl_upd_addr = '0;
  logic [7:0] ctl_upd_data = '0;

  int n_cmp = 0, n_bad = 0;
  logic [7:0] mdl [VDEPTH];
  logic sh_vld = 0;
  logic [VW-1:0] sh_addr = '0;
  logic [7:0] sh_val = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mbx_mailbox_top #(.RESP_DELAY(DLY), .VADDR_W(VW)) dut_i (
    .clk(clk), .rst(rst), .host_sel(host_sel), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .wdog_evt(wdog_evt), .ctl_upd_we(ctl_upd_we), .ctl_upd_addr(ctl_upd_addr),
    .ctl_upd_data(ctl_upd_data), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic hw(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    host_sel = 1; host_we = 1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_sel = 0; host_we = 0;
  endtask

  task automatic hr(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    host_sel = 1; host_we = 0; host_addr = a;
    @(negedge clk);
    host_sel = 0;
    d = host_rdata;
  endtask

  task automatic upd(input logic [VW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    ctl_upd_we = 1; ctl_upd_addr = a; ctl_upd_data = d;
    @(negedge clk);
    ctl_upd_we = 0;
    mdl[a] = d;
  endtask

  function automatic logic [7:0] exp_status(input logic [7:0] op, input logic [7:0] cnt,
                                            input logic [15:0] va);
    if (!((op == 8'h02 || op == 8'h03) && cnt == 8'd1)) return 8'h80;
    if (va >= 16'(VDEPTH)) return 8'h81;
    return 8'h01;
  endfunction

  // Reference model step: returns expected result code and packet value byte.
  task automatic model_cmd(input logic [7:0] op, input logic [7:0] cnt, input logic [15:0] va,
                           input logic [7:0] val, output logic [7:0] est, output logic [7:0] erv);
    logic [VW-1:0] a;
    est = exp_status(op, cnt, va);
    erv = val;
    a = va[VW-1:0];
    if (est == 8'h01 && op == 8'h03) mdl[a] = val;
    if (est == 8'h01 && op == 8'h02) begin
      if (!a[0]) begin
        erv = mdl[a]; sh_vld = 1; sh_addr = a | VW'(1); sh_val = mdl[a | VW'(1)];
      end else if (sh_vld && sh_addr == a) begin
        erv = sh_val; sh_vld = 0;
      end else begin
        erv = mdl[a];
      end
    end
  endtask

  task automatic run_cmd(input logic [7:0] op, input logic [7:0] cnt, input logic [15:0] va,
                         input logic [7:0] val, output logic [7:0] st, output logic [7:0] rv);
    int n;
    n = -1;
    hw(4'd3, 8'h80); hw(4'd2, 8'h00);
    hw(4'd4, op); hw(4'd5, cnt);
    hw(4'd2, 8'h04);
    hw(4'd4, val); hw(4'd6, va[7:0]); hw(4'd7, va[15:8]);
    hw(4'd0, 8'h01);
    for (int i = 1; i <= DLY + 20; i++) begin
      @(negedge clk);
      if (irq && n < 0) n = i;
    end
    check("R4 completion latency", n, DLY + 2);
    hr(4'd1, st);
    hw(4'd1, st);
    hw(4'd8, 8'h01);
    hr(4'd4, rv);
  endtask

  task automatic cmd_and_check(input logic [7:0] op, input logic [7:0] cnt, input logic [15:0] va,
                               input logic [7:0] val, input string tag);
    logic [7:0] st, rv, est, erv;
    model_cmd(op, cnt, va, val, est, erv);
    run_cmd(op, cnt, va, val, st, rv);
    check({tag, " R7 result code"}, st, est);
    check({tag, " R6 packet value byte"}, rv, erv);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL R4 watchdog expired act=running exp=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] d, st, rv;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 0;

    // R1 reset state
    check("R1 irq", irq, 0);
    for (int o = 0; o < 10; o++) begin
      hr(4'(o), d);
      check("R1 offset read", d, 0);
    end

    // R14 fill array via update port
    for (int a = 0; a < VDEPTH; a++) upd(VW'(a), 8'(a * 7 + 3));

    // R2 pointer
    hw(4'd2, 8'h5C); hw(4'd3, 8'hA1);
    hr(4'd2, d); check("R2 ptr low", d, 8'h5C);
    hr(4'd3, d); check("R2 ptr high", d, 8'hA1);

    // R3 window outside region ignored
    hw(4'd4, 8'hAA); hr(4'd4, d); check("R3 outside region read", d, 0);
    hw(4'd3, 8'h80); hw(4'd2, 8'h06);
    hw(4'd6, 8'h3C); hr(4'd6, d); check("R3 index past end", d, 0);
    hw(4'd5, 8'h5A);
    hw(4'd2, 8'h07); hr(4'd4, d); check("R3 relative index", d, 8'h5A);

    // R14 / R6 read of update-port value
    cmd_and_check(8'h02, 8'd1, 16'd10, 8'h00, "R14");
    // R5 write then read back
    cmd_and_check(8'h03, 8'd1, 16'd21, 8'hC3, "R5");
    cmd_and_check(8'h02, 8'd1, 16'd21, 8'h00, "R5 readback");
    // R7 errors leave registers unchanged
    cmd_and_check(8'h03, 8'd2, 16'd22, 8'h11, "R7 bad count");
    cmd_and_check(8'h07, 8'd1, 16'd22, 8'h12, "R7 bad opcode");
    cmd_and_check(8'h03, 8'd1, 16'h0140, 8'h13, "R7 bad address");
    cmd_and_check(8'h02, 8'd1, 16'd22, 8'h00, "R7 unchanged");
    // R12 partner latch with update in between
    cmd_and_check(8'h02, 8'd1, 16'd30, 8'h00, "R12 even");
    upd(VW'(31), 8'hEE);
    cmd_and_check(8'h02, 8'd1, 16'd31, 8'h00, "R12 latched odd");
    cmd_and_check(8'h02, 8'd1, 16'd31, 8'h00, "R12 live after consume");

    // R8 partial clear of result code
    run_cmd(8'h03, 8'd1, 16'h0080, 8'h00, st, rv);
    check("R7 out of range", st, 8'h81);
    hw(4'd1, 8'h00);
    run_cmd(8'h03, 8'd1, 16'h0099, 8'h00, st, rv);
    hw(4'd1, 8'h81);
    run_cmd(8'h02, 8'd3, 16'd1, 8'h00, st, rv);
    hw(4'd1, 8'h01);
    hr(4'd1, d); check("R8 partial clear", d, 8'h00);
    run_cmd(8'h02, 8'd1, 16'h0200, 8'h00, st, rv);
    // status already cleared by run_cmd write-back; repost and clear partially
    hw(4'd3, 8'h80); hw(4'd2, 8'h00); hw(4'd4, 8'h02); hw(4'd5, 8'h01);
    hw(4'd2, 8'h04); hw(4'd6, 8'h00); hw(4'd7, 8'h02);
    hw(4'd0, 8'h01);
    repeat (DLY + 4) @(negedge clk);
    hw(4'd1, 8'h01);
    hr(4'd1, d); check("R8 clear bit 0 only", d, 8'h80);
    hr(4'd8, d); check("R9 completion bit", d, 8'h01);
    hw(4'd8, 8'h01);
    hr(4'd8, d); check("R9 cleared", d, 8'h00);
    hw(4'd1, 8'hFF);

    // R4 wrong doorbell value
    hw(4'd0, 8'h02);
    repeat (DLY + 6) @(negedge clk);
    check("R4 non-go doorbell", irq, 0);

    // R11 doorbell while busy
    hw(4'd0, 8'h01);
    hw(4'd0, 8'h01);
    repeat (DLY + 4) @(negedge clk);
    check("R11 first completion", irq, 1);
    hw(4'd8, 8'h01);
    hw(4'd1, 8'hFF);
    repeat (DLY + 6) @(negedge clk);
    check("R11 no second completion", irq, 0);

    // R10 / R13 watchdog source
    @(negedge clk); wdog_evt = 1;
    @(negedge clk); @(negedge clk);
    check("R13 irq from watchdog", irq, 1);
    hr(4'd9, d); check("R10 wdog bit", d, 8'h01);
    hw(4'd9, 8'h01);
    repeat (3) @(negedge clk);
    hr(4'd9, d); check("R10 no reset while high", d, 8'h00);
    check("R13 irq low", irq, 0);
    wdog_evt = 0;

    // Random phase with a fixed seed
    for (int k = 0; k < 60; k++) begin
      logic [7:0] op, cnt, val;
      logic [15:0] va;
      int r;
      r = $urandom % 8;
      op = (r < 3) ? 8'h02 : (r < 6) ? 8'h03 : (r == 6) ? 8'($urandom) : 8'h02;
      cnt = (r == 7) ? 8'($urandom % 4) : 8'd1;
      va = ($urandom % 8 == 0) ? 16'($urandom) | 16'h0040 : 16'($urandom % VDEPTH);
      val = 8'($urandom);
      if ($urandom % 2 == 1) upd(VW'($urandom), 8'($urandom));
      cmd_and_check(op, cnt, va, val, "R12 random");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule